// File: doc/BRIEF.md
# Directional Rectangle Copy Engine

This block moves a rectangle of pixels from one place in a byte-addressed frame memory to another. Software presents the source and destination anchors, the rectangle size, the pitches and base offsets, a pixel-format code, a raster-operation code and two traversal-direction bits, then pulses `start`. The engine checks every parameter in the start cycle. If they are valid it latches them, then moves the rectangle one byte at a time through a synchronous byte-wide memory port. Each byte takes a read cycle and then a write cycle.

The direction bits serve two purposes. They say whether the given X/Y anchor marks the near corner or the far corner of the rectangle, and they set the order in which rows and the bytes within a row are visited. This lets a copy whose source and destination overlap finish without reading a byte it has already overwritten. When a copy ends, the engine reports updated destination coordinates, so a later operation can continue from where this one stopped.

Top module: `rect_blit`

## Requirements
- R1: The low 4 bits of `pix_fmt` give the bytes per pixel: code 2 gives 1, codes 3 and 4 give 2, code 5 gives 3 and code 6 gives 4. Any other code sets `err` and performs no memory write.
- R2: When `dir_ltr` is 0, the starting X of both source and destination is the given X + 1 − width (16-bit wraparound). When `dir_ttb` is 0, the starting Y is the given Y + 1 − height. When a bit is 1, the given coordinate is used unchanged.
- R3: With `dir_ttb` = 1, rows go from row 0 to row height−1. Otherwise they go from the last row up to row 0. A row's first byte sits at base + startX·bytes_per_pixel + (startY + row)·pitch.
- R4: Within a row, bytes go in ascending address order when `dir_ltr` = 1 and in descending order otherwise. An overlapping copy therefore gives the result of moving each byte in that order.
- R5: When `own_geom` = 1, the source and destination use their own pitch and offset inputs. When it is 0, both use `def_pitch` and `def_off`, and the per-side pitch and offset inputs have no effect.
- R6: If the selected source or destination pitch is 0, the operation is aborted with `err` = 1 and no writes.
- R7: The operation is aborted with `err` = 1 and no writes in any of these cases: a starting X or Y is above 0x3FFF, a side's base is at or beyond MEM_SIZE, or base + startX + (startY + height)·pitch reaches MEM_SIZE.
- R8: After a successful copy, `wb_dst_x` = startX + width if `dir_ltr` = 1 and startX otherwise. `wb_dst_y` = startY + height if `dir_ttb` = 1 and startY otherwise. Both hold their value through an aborted or skipped operation and change only in a `done` cycle.
- R9: Only raster code 0xCC copies. Any other code, provided the destination checks pass, ends with `done`, `err` = 0, no writes and unchanged write-back coordinates. Destination checks (format, destination pitch, destination range) are made before the raster code.
- R10: `busy` rises in the cycle after an accepted `start` and stays high until the cycle that carries the one-cycle `done` pulse. `start` and every parameter input are ignored while busy. An abort or a skipped operation pulses `done` in the cycle after `start` without ever raising `busy`.
- R11: Every byte is a `mem_rd` cycle followed immediately by a `mem_wr` cycle that writes the data returned one cycle after the read. The two strobes are never active together, so a copy of N bytes keeps `busy` high for exactly 2·N cycles.
- R12: A width or height of 0 that passes all checks completes with no memory access and still updates the write-back coordinates by R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| rop_code | input | 8 | Raster operation code, 0xCC = source copy |
| pix_fmt | input | 4 | Pixel format code |
| dir_ltr | input | 1 | 1 = left-to-right traversal |
| dir_ttb | input | 1 | 1 = top-to-bottom traversal |
| own_geom | input | 1 | 1 = per-side pitch/offset, 0 = shared default |
| src_x | input | CW | Source X anchor |
| src_y | input | CW | Source Y anchor |
| dst_x | input | CW | Destination X anchor |
| dst_y | input | CW | Destination Y anchor |
| width | input | CW | Rectangle width in pixels |
| height | input | CW | Rectangle height in rows |
| src_pitch | input | PW | Source row pitch in bytes |
| dst_pitch | input | PW | Destination row pitch in bytes |
| def_pitch | input | PW | Shared default pitch |
| src_off | input | OW | Source base offset |
| dst_off | input | OW | Destination base offset |
| def_off | input | OW | Shared default offset |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation was rejected |
| wb_dst_x | output | CW | Updated destination X |
| wb_dst_y | output | CW | Updated destination Y |
| mem_addr | output | AW | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after `mem_rd` |

## Verification
A wrong row or byte counter, or a wrong direction flag held in the latched state, shows up as a wrong write address or wrong data within one read/write pair. The final memory image of an overlapping copy then differs from the byte-ordered result. A wrong loop end moves the `done` cycle, which appears in the busy-cycle count, or it leaves bytes unwritten. A stale anchor or base corrupts the write-back coordinates when `done` pulses, or turns an accepted operation into an abort in the cycle right after `start`.

// File: rtl/blit_pkg.sv
package blit_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} blit_state_e;
    localparam logic [7:0] ROP_SRC_COPY = 8'hCC;
    localparam int         COORD_MAX    = 16'h3FFF;
endpackage

// File: rtl/blit_pix_decode.sv
module blit_pix_decode (
    input  logic [3:0] code,
    output logic [2:0] bytes_pp,
    output logic       ok
);
    always_comb begin
        ok = 1'b1;
        case (code)
            4'd2:       bytes_pp = 3'd1;
            4'd3, 4'd4: bytes_pp = 3'd2;
            4'd5:       bytes_pp = 3'd3;
            4'd6:       bytes_pp = 3'd4;
            default: begin
                bytes_pp = 3'd0;
                ok       = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/blit_anchor.sv
module blit_anchor #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    input  logic [CW-1:0] w,
    input  logic [CW-1:0] h,
    input  logic          ltr,
    input  logic          ttb,
    output logic [CW-1:0] sx,
    output logic [CW-1:0] sy,
    output logic          oor
);
    import blit_pkg::*;
    // far-corner anchors move back to the near corner
    assign sx  = ltr ? x : CW'(x + CW'(1) - w);
    assign sy  = ttb ? y : CW'(y + CW'(1) - h);
    assign oor = (32'(sx) > COORD_MAX) || (32'(sy) > COORD_MAX);
endmodule

// File: rtl/blit_reach.sv
module blit_reach #(
    parameter int CW       = 16,
    parameter int PW       = 16,
    parameter int OW       = 24,
    parameter int MEM_SIZE = 4096
) (
    input  logic [OW-1:0] base,
    input  logic [CW-1:0] sx,
    input  logic [CW-1:0] sy,
    input  logic [CW-1:0] h,
    input  logic [PW-1:0] pitch,
    output logic          bad
);
    localparam int WW = OW + CW + PW + 2;
    logic [WW-1:0] reach;
    assign reach = WW'(base) + WW'(sx) + (WW'(sy) + WW'(h)) * WW'(pitch);
    assign bad   = (pitch == '0) || (WW'(base) >= WW'(MEM_SIZE)) || (reach >= WW'(MEM_SIZE));
endmodule

// File: rtl/rect_blit.sv
module rect_blit #(
    parameter int CW       = 16,
    parameter int PW       = 16,
    parameter int OW       = 24,
    parameter int AW       = 12,
    parameter int MEM_SIZE = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    rop_code,
    input  logic [3:0]    pix_fmt,
    input  logic          dir_ltr,
    input  logic          dir_ttb,
    input  logic          own_geom,
    input  logic [CW-1:0] src_x,
    input  logic [CW-1:0] src_y,
    input  logic [CW-1:0] dst_x,
    input  logic [CW-1:0] dst_y,
    input  logic [CW-1:0] width,
    input  logic [CW-1:0] height,
    input  logic [PW-1:0] src_pitch,
    input  logic [PW-1:0] dst_pitch,
    input  logic [PW-1:0] def_pitch,
    input  logic [OW-1:0] src_off,
    input  logic [OW-1:0] dst_off,
    input  logic [OW-1:0] def_off,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [CW-1:0] wb_dst_x,
    output logic [CW-1:0] wb_dst_y,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata
);
    import blit_pkg::*;

    localparam int WW = OW + CW + PW + 2;
    localparam int BW = CW + 2;
    localparam int NS = 2;   // side 0 = source, side 1 = destination

    typedef struct packed {
        blit_state_e   st;
        logic          ltr;
        logic          ttb;
        logic [2:0]    bpp;
        logic [OW-1:0] sbase;
        logic [OW-1:0] dbase;
        logic [PW-1:0] sp;
        logic [PW-1:0] dp;
        logic [CW-1:0] ssx;
        logic [CW-1:0] ssy;
        logic [CW-1:0] dsx;
        logic [CW-1:0] dsy;
        logic [CW-1:0] w;
        logic [CW-1:0] h;
        logic [CW-1:0] row;
        logic [BW-1:0] col;
        logic          done;
        logic          err;
        logic [CW-1:0] wbx;
        logic [CW-1:0] wby;
    } regs_t;

    regs_t q, d;

    // ---- start-time decode and checks ----
    logic [2:0] pix_bytes;
    logic       pix_ok;

    blit_pix_decode u_pix (.code(pix_fmt), .bytes_pp(pix_bytes), .ok(pix_ok));

    logic [CW-1:0] side_x [NS];
    logic [CW-1:0] side_y [NS];
    logic [PW-1:0] side_p [NS];
    logic [OW-1:0] side_b [NS];
    logic [CW-1:0] anc_x  [NS];
    logic [CW-1:0] anc_y  [NS];
    logic          side_oor [NS];
    logic          side_bad [NS];

    assign side_x[0] = src_x;
    assign side_y[0] = src_y;
    assign side_x[1] = dst_x;
    assign side_y[1] = dst_y;
    assign side_p[0] = own_geom ? src_pitch : def_pitch;
    assign side_p[1] = own_geom ? dst_pitch : def_pitch;
    assign side_b[0] = own_geom ? src_off : def_off;
    assign side_b[1] = own_geom ? dst_off : def_off;

    for (genvar g = 0; g < NS; g++) begin : g_side
        blit_anchor #(.CW(CW)) u_anc (
            .x(side_x[g]), .y(side_y[g]), .w(width), .h(height),
            .ltr(dir_ltr), .ttb(dir_ttb),
            .sx(anc_x[g]), .sy(anc_y[g]), .oor(side_oor[g])
        );
        blit_reach #(.CW(CW), .PW(PW), .OW(OW), .MEM_SIZE(MEM_SIZE)) u_reach (
            .base(side_b[g]), .sx(anc_x[g]), .sy(anc_y[g]), .h(height),
            .pitch(side_p[g]), .bad(side_bad[g])
        );
    end

    logic dst_fail, src_fail;
    assign dst_fail = !pix_ok || side_oor[1] || side_bad[1];
    assign src_fail = side_oor[0] || side_bad[0];

    function automatic logic [AW-1:0] byte_addr(
        input logic [OW-1:0] base, input logic [CW-1:0] sx, input logic [CW-1:0] sy,
        input logic [PW-1:0] pitch, input logic [CW-1:0] ridx, input logic [BW-1:0] bidx,
        input logic [2:0] bpp);
        logic [WW-1:0] a;
        a = WW'(base) + WW'(sx) * WW'(bpp) + (WW'(sy) + WW'(ridx)) * WW'(pitch) + WW'(bidx);
        return AW'(a);
    endfunction

    // ---- traversal ----
    logic [BW-1:0] row_bytes;
    logic [CW-1:0] row_idx;
    logic [BW-1:0] byte_idx;
    logic          last_col, last_row;

    assign row_bytes = BW'(q.w) * BW'(q.bpp);
    assign row_idx   = q.ttb ? q.row : CW'(q.h - CW'(1) - q.row);
    assign byte_idx  = q.ltr ? q.col : BW'(row_bytes - BW'(1) - q.col);
    assign last_col  = (q.col == BW'(row_bytes - BW'(1)));
    assign last_row  = (q.row == CW'(q.h - CW'(1)));

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.err  = 1'b0;
                    d.ltr  = dir_ltr;
                    d.ttb  = dir_ttb;
                    d.bpp  = pix_bytes;
                    d.sbase = side_b[0];
                    d.dbase = side_b[1];
                    d.sp   = side_p[0];
                    d.dp   = side_p[1];
                    d.ssx  = anc_x[0];
                    d.ssy  = anc_y[0];
                    d.dsx  = anc_x[1];
                    d.dsy  = anc_y[1];
                    d.w    = width;
                    d.h    = height;
                    d.row  = '0;
                    d.col  = '0;
                    if (dst_fail) begin
                        d.err  = 1'b1;
                        d.done = 1'b1;
                    end else if (rop_code != ROP_SRC_COPY) begin
                        d.done = 1'b1;
                    end else if (src_fail) begin
                        d.err  = 1'b1;
                        d.done = 1'b1;
                    end else if (width == '0 || height == '0) begin
                        d.done = 1'b1;
                        d.wbx  = dir_ltr ? CW'(anc_x[1] + width)  : anc_x[1];
                        d.wby  = dir_ttb ? CW'(anc_y[1] + height) : anc_y[1];
                    end else begin
                        d.st = ST_RD;
                    end
                end
            end
            ST_RD: d.st = ST_WR;
            ST_WR: begin
                d.st  = ST_RD;
                d.col = BW'(q.col + BW'(1));
                if (last_col) begin
                    d.col = '0;
                    d.row = CW'(q.row + CW'(1));
                    if (last_row) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.wbx  = q.ltr ? CW'(q.dsx + q.w) : q.dsx;
                        d.wby  = q.ttb ? CW'(q.dsy + q.h) : q.dsy;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign err       = q.err;
    assign wb_dst_x  = q.wbx;
    assign wb_dst_y  = q.wby;
    assign mem_rd    = (q.st == ST_RD);
    assign mem_wr    = (q.st == ST_WR);
    assign mem_wdata = mem_rdata;
    assign mem_addr  = (q.st == ST_WR)
                     ? byte_addr(q.dbase, q.dsx, q.dsy, q.dp, row_idx, byte_idx, q.bpp)
                     : byte_addr(q.sbase, q.ssx, q.ssy, q.sp, row_idx, byte_idx, q.bpp);
endmodule

// File: rtl/blit_checks.sv
module blit_checks #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [CW-1:0] wb_dst_x,
    input logic [CW-1:0] wb_dst_y
);
    AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));                                              // R11
    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd));                                         // R11
    AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);                                                // R11
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                                   // R10
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr));                                   // R10
    AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(wb_dst_x) && $stable(wb_dst_y)));               // R8
    AST_ERR_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);                                                    // R7
endmodule

bind rect_blit blit_checks #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .wb_dst_x(wb_dst_x), .wb_dst_y(wb_dst_y)
);

// File: tb/sim_rect_blit.sv
`timescale 1ns/1ps
module sim_rect_blit;
    localparam int MSZ = 4096;

    typedef struct packed {
        logic [7:0]  rop;
        logic [3:0]  fmt;
        logic        ltr;
        logic        ttb;
        logic        own;
        logic [15:0] sx, sy, dx, dy, w, h, sp, dp, dfp;
        logic [23:0] so, doff, dfo;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{8'hCC,4'd2,1'b1,1'b1,1'b1,16'd2,16'd1,16'd10,16'd5,16'd4,16'd3,16'd64,16'd64,16'd0,24'd0,24'd0,24'd0},            // R1 R3 8bpp forward
        '{8'hCC,4'd3,1'b1,1'b1,1'b1,16'd1,16'd2,16'd3,16'd4,16'd3,16'd2,16'd32,16'd32,16'd0,24'd512,24'd1024,24'd0},        // R1 16bpp offsets
        '{8'hCC,4'd4,1'b0,1'b0,1'b1,16'd10,16'd6,16'd12,16'd7,16'd4,16'd3,16'd64,16'd64,16'd0,24'd0,24'd0,24'd0},           // R2 R3 reverse overlap
        '{8'hCC,4'd5,1'b0,1'b1,1'b1,16'd5,16'd0,16'd6,16'd0,16'd4,16'd2,16'd64,16'd64,16'd0,24'd2048,24'd2048,24'd0},       // R4 same-row shift
        '{8'hCC,4'd6,1'b1,1'b0,1'b0,16'd0,16'd3,16'd1,16'd5,16'd3,16'd2,16'd0,16'd0,16'd128,24'd3000,24'd3000,24'd256},     // R5 defaults
        '{8'hCC,4'd7,1'b1,1'b1,1'b1,16'd0,16'd0,16'd4,16'd4,16'd2,16'd2,16'd64,16'd64,16'd0,24'd0,24'd0,24'd0},             // R1 bad fmt
        '{8'hCC,4'd2,1'b1,1'b1,1'b1,16'd0,16'd0,16'd4,16'd4,16'd2,16'd2,16'd64,16'd0,16'd0,24'd0,24'd0,24'd0},              // R6 dst pitch 0
        '{8'hCC,4'd2,1'b1,1'b1,1'b1,16'd0,16'd0,16'd4,16'd4,16'd2,16'd2,16'd0,16'd64,16'd0,24'd0,24'd0,24'd0},              // R6 src pitch 0
        '{8'hCC,4'd2,1'b1,1'b1,1'b1,16'd0,16'd0,16'h4000,16'd4,16'd2,16'd2,16'd64,16'd64,16'd0,24'd0,24'd0,24'd0},          // R7 X limit
        '{8'hCC,4'd2,1'b1,1'b1,1'b1,16'd0,16'd0,16'd0,16'd60,16'd2,16'd4,16'd64,16'd64,16'd0,24'd0,24'd0,24'd0},            // R7 reach = end
        '{8'hCC,4'd2,1'b1,1'b1,1'b1,16'd0,16'd0,16'd0,16'd59,16'd2,16'd4,16'd64,16'd64,16'd0,24'd0,24'd0,24'd0},            // R7 reach just below
        '{8'h5A,4'd2,1'b1,1'b1,1'b1,16'd0,16'd0,16'd8,16'd8,16'd2,16'd2,16'd64,16'd64,16'd0,24'd0,24'd0,24'd0},             // R9 other rop
        '{8'hCC,4'd2,1'b1,1'b1,1'b1,16'd0,16'd0,16'd20,16'd9,16'd0,16'd3,16'd64,16'd64,16'd0,24'd0,24'd0,24'd0},            // R12 zero width
        '{8'hCC,4'd2,1'b1,1'b1,1'b1,16'd0,16'd0,16'd4,16'd4,16'd2,16'd2,16'd64,16'd64,16'd0,24'd4096,24'd0,24'd0},          // R7 src base
        '{8'hCC,4'd2,1'b0,1'b1,1'b1,16'd8,16'd0,16'd2,16'd0,16'd5,16'd1,16'd64,16'd64,16'd0,24'd0,24'd0,24'd0},             // R2 R7 wrap
        '{8'h5A,4'd7,1'b1,1'b1,1'b1,16'd0,16'd0,16'd4,16'd4,16'd2,16'd2,16'd64,16'd64,16'd0,24'd0,24'd0,24'd0}              // R9 dst checks first
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        start = 1'b0;
    vec_t        cur = '0;
    logic        busy, done, err, mem_rd, mem_wr;
    logic [15:0] wbx, wby;
    logic [11:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    rect_blit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .rop_code(cur.rop), .pix_fmt(cur.fmt),
        .dir_ltr(cur.ltr), .dir_ttb(cur.ttb), .own_geom(cur.own),
        .src_x(cur.sx), .src_y(cur.sy), .dst_x(cur.dx), .dst_y(cur.dy),
        .width(cur.w), .height(cur.h), .src_pitch(cur.sp), .dst_pitch(cur.dp),
        .def_pitch(cur.dfp), .src_off(cur.so), .dst_off(cur.doff), .def_off(cur.dfo),
        .busy(busy), .done(done), .err(err), .wb_dst_x(wbx), .wb_dst_y(wby),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] pat(int i, int seed);
        return 8'(i * 13 + seed * 29 + i / 7);
    endfunction

    // memory model: synchronous, one-cycle read latency
    logic [7:0] mem [MSZ];
    logic       init_req = 1'b0;
    int         init_seed = 0;
    always @(posedge clk) begin
        if (init_req) begin
            for (int i = 0; i < MSZ; i++) mem[i] <= pat(i, init_seed);
        end else begin
            if (mem_wr) mem[mem_addr] <= mem_wdata;
            if (mem_rd) mem_rdata <= mem[mem_addr];
        end
    end

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            nfail = nfail + 1;
            nchk  = nchk + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 190000)", cyc);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk = nchk + 1;
        if (!ok) begin
            nfail = nfail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reference model built from the requirements
    logic [7:0]  ref_mem [MSZ];
    logic [15:0] exp_x = '0, exp_y = '0;
    bit          exp_err;
    int          exp_bytes;

    task automatic ref_run(input vec_t v);
        int          b;
        longint      sp, dp, sb, db, rb, srow, drow;
        logic [15:0] ssx, ssy, dsx, dsy;
        bit          dfail, sfail;
        case (v.fmt)
            4'd2: b = 1;
            4'd3, 4'd4: b = 2;
            4'd5: b = 3;
            4'd6: b = 4;
            default: b = 0;
        endcase
        sp = v.own ? longint'(v.sp) : longint'(v.dfp);
        dp = v.own ? longint'(v.dp) : longint'(v.dfp);
        sb = v.own ? longint'(v.so) : longint'(v.dfo);
        db = v.own ? longint'(v.doff) : longint'(v.dfo);
        ssx = v.ltr ? v.sx : 16'(v.sx + 16'd1 - v.w);
        dsx = v.ltr ? v.dx : 16'(v.dx + 16'd1 - v.w);
        ssy = v.ttb ? v.sy : 16'(v.sy + 16'd1 - v.h);
        dsy = v.ttb ? v.dy : 16'(v.dy + 16'd1 - v.h);
        dfail = (b == 0) || (dp == 0) || (dsx > 16'h3FFF) || (dsy > 16'h3FFF) || (db >= MSZ)
              || (db + dsx + (longint'(dsy) + v.h) * dp >= MSZ);
        sfail = (sp == 0) || (ssx > 16'h3FFF) || (ssy > 16'h3FFF) || (sb >= MSZ)
              || (sb + ssx + (longint'(ssy) + v.h) * sp >= MSZ);
        exp_bytes = 0;
        exp_err   = 1'b0;
        if (dfail) exp_err = 1'b1;
        else if (v.rop != 8'hCC) exp_err = 1'b0;
        else if (sfail) exp_err = 1'b1;
        else begin
            rb = longint'(v.w) * b;
            for (int r = 0; r < int'(v.h); r++) begin
                int ri = v.ttb ? r : int'(v.h) - 1 - r;
                srow = sb + longint'(ssx) * b + (longint'(ssy) + ri) * sp;
                drow = db + longint'(dsx) * b + (longint'(dsy) + ri) * dp;
                for (longint k = 0; k < rb; k++) begin
                    longint kb = v.ltr ? k : rb - 1 - k;
                    ref_mem[(drow + kb) % MSZ] = ref_mem[(srow + kb) % MSZ];
                    exp_bytes++;
                end
            end
            exp_x = v.ltr ? 16'(dsx + v.w) : dsx;
            exp_y = v.ttb ? 16'(dsy + v.h) : dsy;
        end
    endtask

    task automatic load_mem(input int seed);
        @(negedge clk);
        init_seed = seed;
        init_req  = 1'b1;
        @(negedge clk);
        init_req  = 1'b0;
        for (int i = 0; i < MSZ; i++) ref_mem[i] = pat(i, seed);
    endtask

    task automatic wait_done(output int bcnt);
        int guard = 0;
        bcnt = 0;
        while (!done && guard < 100000) begin
            if (busy) bcnt++;
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic check_result(input string req, input int bcnt);
        int bad = 0;
        for (int i = 0; i < MSZ; i++) if (mem[i] !== ref_mem[i]) bad++;
        chk(bad == 0, {req, " memory image mismatches"}, bad, 0);
        chk(err == exp_err, {req, " err"}, err, exp_err);
        chk(wbx == exp_x, "R8 wb_dst_x", wbx, exp_x);
        chk(wby == exp_y, "R8 wb_dst_y", wby, exp_y);
        chk(bcnt == 2 * exp_bytes, "R11 busy cycles", bcnt, 2 * exp_bytes);
    endtask

    initial begin
        int bcnt;
        repeat (3) @(negedge clk);
        // reset state
        chk(!busy && !done && !err, "R10 reset flags", {busy, done, err}, 0);
        chk(!mem_rd && !mem_wr, "R11 reset strobes", {mem_rd, mem_wr}, 0);
        chk(wbx == 0 && wby == 0, "R8 reset coords", {wbx, wby}, 0);
        rst_n = 1'b1;

        // table walk (tags per row above: R1 R2 R3 R4 R5 R6 R7 R9 R12)
        for (int n = 0; n < NV; n++) begin
            load_mem(n);
            cur = VECS[n];
            ref_run(VECS[n]);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done(bcnt);
            check_result($sformatf("R3 R4 vec%0d", n), bcnt);
        end

        // R10: start and parameter changes while busy are ignored
        load_mem(40);
        cur = VECS[0];
        ref_run(VECS[0]);
        start = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R10 busy after start", busy, 1);
        cur = VECS[2];
        cur.dx = 16'd30;
        @(negedge clk);
        start = 1'b0;
        cur = VECS[1];
        wait_done(bcnt);
        check_result("R10 ignore-while-busy", bcnt + 1);
        @(negedge clk);
        chk(done == 1'b0, "R10 done single cycle", done, 0);

        // R10: abort pulses done without busy
        cur = VECS[5];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done && !busy && err, "R10 abort done no busy", {done, busy, err}, 3'b101);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule